// File: doc/BRIEF.md
# Banked internal data memory unit

This block is the internal data space of a small 8-bit controller. It holds 256 bytes of general RAM and a separate 128-byte window of special function storage. Every access carries an addressing mode, and the mode decides where the address lands. The same byte address from 80H to FFH reaches upper RAM when it is used indirectly, and it reaches the special function window when it is used directly. The lowest 32 RAM bytes form four banks of eight working registers. Two bank-select inputs choose which bank a register number refers to. Sixteen bytes just above the banks can also be reached one bit at a time. An internal stack pointer supports push and pop over the whole RAM.

Instruction decode and the external data bus are outside the block. The special function window is plain storage here and has no side effects. A core drives a mode, an address, write data, a write strobe and the bank-select bits. Read data comes back combinationally in the same cycle. Writes and stack pointer moves take effect at the rising clock edge.

Top module: `idm_top`

## Requirements
- R1: After reset, every RAM byte and every special function byte reads 00H, and the stack pointer output reads 07H.
- R2: In direct mode (mode code 0), addresses 00H to 7FH read and write lower RAM at that same address.
- R3: In direct mode, addresses 80H to FFH read and write special function byte (address − 80H). Upper RAM at the same address is left unchanged.
- R4: In indirect mode (mode code 1), address bit 0 selects the pointer: R0 when it is 0 and R1 when it is 1, both taken from the active bank. The access goes to RAM at the pointer value, anywhere from 00H to FFH, and never to the special function window.
- R5: In register mode (mode code 2), register number n = address[2:0] reaches RAM byte bank×8 + n, where bank = bank_sel_i (RS1 is bit 1, RS0 is bit 0).
- R6: In bit mode (mode code 3), bit address b = address[6:0] selects bit b[2:0] of RAM byte 20H + b[6:3]. Address bit 7 is ignored. A read returns that bit in rdata_o[0] with bits 7:1 at zero. A write loads wdata_i[0] into that bit and leaves the other seven bits of the byte unchanged.
- R7: A push (mode code 4 with we_i high) first increments the stack pointer and then writes wdata_i to RAM at the new value, so the first push after reset writes 08H. In push mode rdata_o reads 00H.
- R8: In pop mode (mode code 5), rdata_o shows RAM at the current stack pointer. With we_i high, the pointer then decrements. A pop writes no storage, and the pointer wraps modulo 256 in both directions.
- R9: A change of bank_sel_i alters no stored byte and applies to the very next register or indirect access.
- R10: With we_i low, no storage byte and no stack pointer bit changes. Mode codes 6 and 7 read 00H and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Addressing mode code |
| addr_i | input | 8 | Byte, register or bit address, depending on the mode |
| wdata_i | input | 8 | Write data; only bit 0 is used in bit mode |
| we_i | input | 1 | Write strobe; in pop mode it acts as the pop strobe |
| bank_sel_i | input | 2 | Active register bank select, RS1 in bit 1 and RS0 in bit 0 |
| rdata_o | output | 8 | Combinational read data |
| sp_o | output | 8 | Current stack pointer |

## Verification
The bench builds the block with its default parameters: a 256-byte RAM, a 128-byte special function window and a stack pointer reset value of 07H. With these values a run of 256 pushes is short enough to carry the pointer all the way round. A run of pops from 07H crosses from 00H to FFH. Both wrap boundaries, and the overlap of the stack with the register banks and the bit-addressable bytes, are therefore exercised within one run.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int BANK_W   = 2;
  localparam int REG_W    = 3;
  localparam int BIT_AW   = 7;
  localparam int SFR_AW   = 7;
  localparam int RAM_SIZE = 1 << AW;
  localparam int SFR_SIZE = 1 << SFR_AW;
  localparam logic [AW-1:0] BIT_BASE = 8'h20;

  typedef enum logic [2:0] {
    M_DIRECT   = 3'd0,
    M_INDIRECT = 3'd1,
    M_BANKREG  = 3'd2,
    M_BIT      = 3'd3,
    M_PUSH     = 3'd4,
    M_POP      = 3'd5,
    M_RSV6     = 3'd6,
    M_RSV7     = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SPC_NONE = 2'd0,
    SPC_RAM  = 2'd1,
    SPC_SFR  = 2'd2
  } space_e;

  // physical byte of register n in the selected bank
  function automatic logic [AW-1:0] bank_reg_addr(input logic [BANK_W-1:0] bank,
                                                  input logic [REG_W-1:0] n);
    return {{(AW-BANK_W-REG_W){1'b0}}, bank, n};
  endfunction

  // byte holding bit address b
  function automatic logic [AW-1:0] bit_byte_addr(input logic [BIT_AW-1:0] b);
    return BIT_BASE + {{(AW-BIT_AW+REG_W){1'b0}}, b[BIT_AW-1:REG_W]};
  endfunction

  // position of bit address b inside its byte
  function automatic logic [REG_W-1:0] bit_pos(input logic [BIT_AW-1:0] b);
    return b[REG_W-1:0];
  endfunction

  // replace one bit of a byte
  function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] byte_in,
                                            input logic [REG_W-1:0] pos,
                                            input logic val);
    logic [DW-1:0] r;
    r = byte_in;
    r[pos] = val;
    return r;
  endfunction
endpackage

// File: rtl/idm_store.sv
module idm_store #(
  parameter int DW       = 8,
  parameter int RAM_SIZE = 256,
  parameter int SFR_SIZE = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(RAM_SIZE)-1:0] ptr_raddr,
  output logic [DW-1:0]               ptr_rdata,
  input  logic [$clog2(RAM_SIZE)-1:0] ram_raddr,
  output logic [DW-1:0]               ram_rdata,
  input  logic [$clog2(SFR_SIZE)-1:0] sfr_raddr,
  output logic [DW-1:0]               sfr_rdata,
  input  logic                        ram_we,
  input  logic                        sfr_we,
  input  logic [$clog2(RAM_SIZE)-1:0] waddr,
  input  logic [DW-1:0]               wdata
);
  localparam int RAW = $clog2(RAM_SIZE);
  localparam int SAW = $clog2(SFR_SIZE);

  logic [DW-1:0] ram [RAM_SIZE];
  logic [DW-1:0] sfr [SFR_SIZE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_SIZE; i++) ram[i] <= '0;
    end else if (ram_we) begin
      ram[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SFR_SIZE; i++) sfr[i] <= '0;
    end else if (sfr_we) begin
      sfr[waddr[SAW-1:0]] <= wdata;
    end
  end

  logic unused_hi;
  assign unused_hi = ^waddr[RAW-1:SAW];

  assign ptr_rdata = ram[ptr_raddr];
  assign ram_rdata = ram[ram_raddr];
  assign sfr_rdata = sfr[sfr_raddr];
endmodule

// File: rtl/idm_addr_map.sv
module idm_addr_map
  import idm_pkg::*;
(
  input  mode_e             mode,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [DW-1:0]     ptr_val,
  input  logic [AW-1:0]     sp,
  output logic [AW-1:0]     ptr_addr,
  output space_e            space,
  output logic [AW-1:0]     tgt_addr,
  output logic              is_bit,
  output logic [REG_W-1:0]  bit_idx,
  output logic              mem_write_ok
);
  always_comb begin
    ptr_addr     = bank_reg_addr(bank, {{(REG_W-1){1'b0}}, addr[0]});
    space        = SPC_NONE;
    tgt_addr     = '0;
    is_bit       = 1'b0;
    bit_idx      = '0;
    mem_write_ok = 1'b0;
    unique case (mode)
      M_DIRECT: begin
        space        = addr[AW-1] ? SPC_SFR : SPC_RAM;
        tgt_addr     = addr;
        mem_write_ok = 1'b1;
      end
      M_INDIRECT: begin
        space        = SPC_RAM;
        tgt_addr     = ptr_val;
        mem_write_ok = 1'b1;
      end
      M_BANKREG: begin
        space        = SPC_RAM;
        tgt_addr     = bank_reg_addr(bank, addr[REG_W-1:0]);
        mem_write_ok = 1'b1;
      end
      M_BIT: begin
        space        = SPC_RAM;
        tgt_addr     = bit_byte_addr(addr[BIT_AW-1:0]);
        is_bit       = 1'b1;
        bit_idx      = bit_pos(addr[BIT_AW-1:0]);
        mem_write_ok = 1'b1;
      end
      M_PUSH: begin
        space        = SPC_RAM;
        tgt_addr     = sp + 1'b1;
        mem_write_ok = 1'b1;
      end
      M_POP: begin
        space        = SPC_RAM;
        tgt_addr     = sp;
      end
      default: begin
        space = SPC_NONE;
      end
    endcase
  end
endmodule

// File: rtl/idm_sp.sv
module idm_sp #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_evt,
  input  logic          pop_evt,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sp <= SP_RST;
    else if (push_evt) sp <= sp + 1'b1;
    else if (pop_evt)  sp <= sp - 1'b1;
  end
endmodule

// File: rtl/idm_top.sv
module idm_top
  import idm_pkg::*;
#(
  parameter logic [7:0] SP_RST = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  input  logic [1:0] bank_sel_i,
  output logic [7:0] rdata_o,
  output logic [7:0] sp_o
);
  mode_e            mode;
  logic [AW-1:0]    ptr_addr;
  logic [DW-1:0]    ptr_val;
  space_e           space;
  logic [AW-1:0]    tgt_addr;
  logic             is_bit;
  logic [REG_W-1:0] bit_idx;
  logic             mem_write_ok;
  logic [DW-1:0]    ram_rd;
  logic [DW-1:0]    sfr_rd;
  logic [DW-1:0]    wr_byte;
  logic             ram_we;
  logic             sfr_we;
  logic             push_evt;
  logic             pop_evt;
  logic [AW-1:0]    sp;

  assign mode = mode_e'(mode_i);

  idm_addr_map u_map (
    .mode         (mode),
    .addr         (addr_i),
    .bank         (bank_sel_i),
    .ptr_val      (ptr_val),
    .sp           (sp),
    .ptr_addr     (ptr_addr),
    .space        (space),
    .tgt_addr     (tgt_addr),
    .is_bit       (is_bit),
    .bit_idx      (bit_idx),
    .mem_write_ok (mem_write_ok)
  );

  idm_store #(.DW(DW), .RAM_SIZE(RAM_SIZE), .SFR_SIZE(SFR_SIZE)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_raddr (ptr_addr),
    .ptr_rdata (ptr_val),
    .ram_raddr (tgt_addr),
    .ram_rdata (ram_rd),
    .sfr_raddr (tgt_addr[SFR_AW-1:0]),
    .sfr_rdata (sfr_rd),
    .ram_we    (ram_we),
    .sfr_we    (sfr_we),
    .waddr     (tgt_addr),
    .wdata     (wr_byte)
  );

  assign push_evt = we_i && (mode == M_PUSH);
  assign pop_evt  = we_i && (mode == M_POP);

  idm_sp #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_evt (push_evt),
    .pop_evt  (pop_evt),
    .sp       (sp)
  );

  assign ram_we  = we_i && mem_write_ok && (space == SPC_RAM);
  assign sfr_we  = we_i && mem_write_ok && (space == SPC_SFR);
  assign wr_byte = is_bit ? put_bit(ram_rd, bit_idx, wdata_i[0]) : wdata_i;

  always_comb begin
    if (mode == M_PUSH)        rdata_o = '0;
    else if (is_bit)           rdata_o = {{(DW-1){1'b0}}, ram_rd[bit_idx]};
    else if (space == SPC_RAM) rdata_o = ram_rd;
    else if (space == SPC_SFR) rdata_o = sfr_rd;
    else                       rdata_o = '0;
  end

  assign sp_o = sp;
endmodule

// File: rtl/idm_checker.sv
module idm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic [7:0] addr_i,
  input logic       we_i,
  input logic [7:0] rdata_o,
  input logic [7:0] sp_o,
  input logic       push_evt,
  input logic       pop_evt,
  input logic       ram_we,
  input logic       sfr_we
);
  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> sp_o == $past(sp_o) + 8'd1);

  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> sp_o == $past(sp_o) - 8'd1);

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_evt && !pop_evt) |=> $stable(sp_o));

  // R3
  direct_hi_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 && we_i && addr_i[7]) |-> (sfr_we && !ram_we));

  // R4
  indirect_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd1 && we_i) |-> (ram_we && !sfr_we));

  // R8
  pop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> (!ram_we && !sfr_we));

  // R6
  bit_read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd3) |-> (rdata_o[7:1] == 7'd0));

  // R10
  no_we_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |-> $onehot0({ram_we, sfr_we}) && !ram_we && !sfr_we);
endmodule

bind idm_top idm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .sp_o     (sp_o),
  .push_evt (push_evt),
  .pop_evt  (pop_evt),
  .ram_we   (ram_we),
  .sfr_we   (sfr_we)
);

// File: tb/tb_idm_top.sv
`timescale 1ns/1ps
module tb_idm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [1:0] bank_sel_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] sp_o;

  int errors = 0;
  int checks = 0;
  int m_ram [256];
  int m_sfr [128];
  int m_sp;
  bit done = 0;

  always #4 clk = ~clk;

  idm_top dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .bank_sel_i(bank_sel_i),
    .rdata_o(rdata_o), .sp_o(sp_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int m, input int a, input int bk);
    int p;
    case (m)
      0: return (a < 128) ? m_ram[a] : m_sfr[a - 128];
      1: begin p = m_ram[bk * 8 + (a % 2)]; return m_ram[p]; end
      2: return m_ram[bk * 8 + (a % 8)];
      3: return (m_ram[32 + (a % 128) / 8] >> (a % 8)) & 1;
      5: return m_ram[m_sp];
      default: return 0;
    endcase
  endfunction

  function automatic void model_write(input int m, input int a, input int w, input int bk);
    int p, by, pos;
    case (m)
      0: if (a < 128) m_ram[a] = w; else m_sfr[a - 128] = w;
      1: begin p = m_ram[bk * 8 + (a % 2)]; m_ram[p] = w; end
      2: m_ram[bk * 8 + (a % 8)] = w;
      3: begin
        by = 32 + (a % 128) / 8; pos = a % 8;
        m_ram[by] = (m_ram[by] & ~(1 << pos)) | ((w & 1) << pos);
      end
      4: begin m_sp = (m_sp + 1) % 256; m_ram[m_sp] = w; end
      5: m_sp = (m_sp + 255) % 256;
      default: ;
    endcase
  endfunction

  // one access: drive after the falling edge, compare, then commit in the model
  task automatic op(input int m, input int a, input int w, input int we, input int bk,
                    input string req);
    @(negedge clk);
    mode_i = 3'(m); addr_i = 8'(a); wdata_i = 8'(w); we_i = 1'(we); bank_sel_i = 2'(bk);
    #1;
    check(req, int'(rdata_o), model_read(m, a, bk));
    check(req, int'(sp_o), m_sp);
    @(posedge clk);
    if (we != 0) model_write(m, a, w, bk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_ram[i] = 0;
    for (int i = 0; i < 128; i++) m_sfr[i] = 0;
    m_sp = 7;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: all storage cleared, pointer at 07H
    for (int a = 0; a < 256; a++) op(0, a, 0, 0, 0, "R1");
    @(negedge clk);
    check("R1", int'(sp_o), 7);

    // R2: lower RAM direct
    op(0, 8'h45, 8'h3C, 1, 0, "R2");
    op(0, 8'h45, 0, 0, 0, "R2");
    op(0, 8'h7F, 8'hE1, 1, 0, "R2");
    op(0, 8'h7F, 0, 0, 0, "R2");

    // R3 and R4: same address, two spaces
    op(0, 8'h90, 8'hAA, 1, 0, "R3");
    op(0, 8'h00, 8'h90, 1, 0, "R4");
    op(1, 0, 0, 0, 0, "R3");
    op(1, 0, 8'h55, 1, 0, "R4");
    op(0, 8'h90, 0, 0, 0, "R3");
    op(1, 0, 0, 0, 0, "R4");
    op(0, 8'h01, 8'hFF, 1, 0, "R4");
    op(1, 1, 8'h77, 1, 0, "R4");
    op(1, 1, 0, 0, 0, "R4");
    op(0, 8'hFF, 0, 0, 0, "R3");

    // R5 and R9: registers in each bank, bank switch every cycle
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) op(2, n, b * 16 + n + 1, 1, b, "R5");
    for (int n = 0; n < 8; n++)
      for (int b = 3; b >= 0; b--) op(2, n, 0, 0, b, "R9");
    for (int a = 0; a < 32; a++) op(0, a, 0, 0, 0, "R9");
    op(0, 8'h18, 8'hC0, 1, 0, "R9");
    op(1, 0, 8'h5A, 1, 3, "R9");
    op(0, 8'hC0, 0, 0, 0, "R9");

    // R6: single bits, neighbours kept, bit 7 of address ignored
    op(0, 8'h25, 8'hA5, 1, 0, "R6");
    op(3, 8'h2B, 1, 1, 0, "R6");
    op(0, 8'h25, 0, 0, 0, "R6");
    op(3, 8'hA8, 0, 1, 0, "R6");
    op(3, 8'h28, 0, 0, 0, "R6");
    op(3, 8'h7F, 1, 1, 0, "R6");
    op(0, 8'h2F, 0, 0, 0, "R6");
    op(3, 8'hFF, 0, 0, 0, "R6");

    // R10: writes with strobe low change nothing
    op(0, 8'h25, 8'h11, 0, 0, "R10");
    op(0, 8'h25, 0, 0, 0, "R10");
    op(4, 0, 8'h99, 0, 0, "R10");
    op(6, 8'h25, 8'h22, 1, 0, "R10");
    op(7, 8'h90, 8'h33, 1, 0, "R10");
    op(0, 8'h25, 0, 0, 0, "R10");

    // R7 and R8: push from reset value, pop back, wrap both ways
    op(4, 0, 8'h61, 1, 0, "R7");
    op(0, 8'h08, 0, 0, 1, "R7");
    op(4, 0, 8'h62, 1, 0, "R7");
    op(5, 0, 0, 1, 0, "R8");
    op(5, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 10; i++) op(5, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 260; i++) op(4, 0, i % 256, 1, 0, "R7");
    for (int i = 0; i < 20; i++) op(5, 0, 0, 1, 0, "R8");

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int m, a, w, we, bk;
      string req;
      m  = $urandom_range(0, 7);
      a  = $urandom_range(0, 255);
      w  = $urandom_range(0, 255);
      we = $urandom_range(0, 1);
      bk = $urandom_range(0, 3);
      case (m)
        0: req = (a < 128) ? "R2" : "R3";
        1: req = "R4";
        2: req = "R5";
        3: req = "R6";
        4: req = "R7";
        5: req = "R8";
        default: req = "R10";
      endcase
      op(m, a, w, we, bk, req);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule